// File: doc/BRIEF.md
# Digital DLL Lock Sequencer

This block sequences the lock procedure of an all-digital delay-locked loop that de-skews a memory clock (reference near 267 MHz, fine steps of roughly 60 ps). It steers three codes in a fixed order. The coarse phase-select code moves first. The fine delay-line code follows. The duty-cycle adjust code moves last. Each code is stepped by one count per evaluation, in the direction the matching detector asks for. A phase ends when that direction reverses between two consecutive evaluations.

Both phase detectors deliver their early/late decision as three redundant copies. The block takes the majority of each triple, so a single upset copy cannot steer a step. The duty-cycle detector delivers one bit. After each code change, decisions are sampled only once a programmable settle time has elapsed, with a floor of four cycles. The block sets a lock flag when fine tuning ends and a corrected flag when duty-cycle tuning ends. If any code is pushed against its end stop, the block sets an error flag and freezes.

Top module: `dll_lock_seq`

## Requirements
- R1: While `rst` is high at a clock edge, every code goes to mid-scale (value 2^(W-1) for a W-bit code), the coarse phase becomes active, and `locked`, `duty_ok` and `err` clear.
- R2: Each phase-detector decision is the majority of its three copies. One disagreeing copy never changes a step, and two disagreeing copies invert it.
- R3: The effective settle time E is `settle`, or 4 when `settle` is below 4. An evaluation happens E cycles after reset release and E cycles after each code change. A code moves by exactly one count per evaluation and never more than once per evaluation.
- R4: In the coarse phase, a voted decision of 1 raises `crs_code` and a voted decision of 0 lowers it. The fine and duty codes do not move during this phase.
- R5: The coarse phase, and likewise the fine phase on `fin_pd`, ends without a step at the first evaluation whose decision differs from the previous one. The end of the fine phase sets `locked`.
- R6: The duty phase runs only after `locked` is set. `duty_hi`=1 lowers `duty_code` and `duty_hi`=0 raises it. The first reversal ends the phase without a step and sets `duty_ok`.
- R7: An evaluation that asks a code to go past its end stop (all ones upward, zero downward), without a reversal, sets `err`. From then on, all codes and flags hold until reset.
- R8: Once set, `locked` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| settle | input | SW | Settle cycles between a code change and the next evaluation |
| crs_pd | input | 3 | Three copies of the coarse early/late decision (1 = raise code) |
| fin_pd | input | 3 | Three copies of the fine early/late decision (1 = raise code) |
| duty_hi | input | 1 | Duty detector: 1 = duty above 50 % |
| crs_code | output | CW | Coarse phase-select code |
| fin_code | output | FW | Fine delay-line code |
| duty_code | output | DW | Duty-cycle adjust code |
| locked | output | 1 | Fine tuning finished |
| duty_ok | output | 1 | Duty correction finished |
| err | output | 1 | A code hit its end stop; sequencer frozen |

## Verification
The assertions assume that `settle` holds steady during a tuning run. This lets the spacing between code changes serve as a check of the settle floor. They also assume that reset is applied from the first clock edge. The bench models the detectors as ideal comparators of each code against a hidden target. On every cycle it flips at most one randomly chosen copy of each triple, which keeps the block within its single-upset assumption. The one directed case with two flipped copies is expected to drive the coarse code into an end stop.

// File: rtl/dll_lock_seq.sv
module dll_lock_seq #(
  parameter int CW = 3,
  parameter int FW = 6,
  parameter int DW = 5,
  parameter int SW = 8,
  parameter int MIN_SETTLE = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] settle,
  input  logic [2:0]    crs_pd,
  input  logic [2:0]    fin_pd,
  input  logic          duty_hi,
  output logic [CW-1:0] crs_code,
  output logic [FW-1:0] fin_code,
  output logic [DW-1:0] duty_code,
  output logic          locked,
  output logic          duty_ok,
  output logic          err
);

  typedef enum logic [1:0] {S_CRS, S_FIN, S_DUTY, S_HOLD} st_t;

  localparam logic [CW-1:0] C_MID = CW'(1) << (CW-1);
  localparam logic [FW-1:0] F_MID = FW'(1) << (FW-1);
  localparam logic [DW-1:0] D_MID = DW'(1) << (DW-1);
  localparam logic [CW-1:0] C_ONE = CW'(1);
  localparam logic [FW-1:0] F_ONE = FW'(1);
  localparam logic [DW-1:0] D_ONE = DW'(1);
  localparam logic [SW-1:0] S_MIN = SW'(MIN_SETTLE);
  localparam logic [SW-1:0] S_ONE = SW'(1);

  st_t           st;
  logic [SW-1:0] wcnt, eff;
  logic          have_prev, prev_up;
  logic          crs_v, fin_v, up, top, bot, flip, blocked, evalv;

  assign crs_v = (crs_pd[0] & crs_pd[1]) | (crs_pd[0] & crs_pd[2]) | (crs_pd[1] & crs_pd[2]);
  assign fin_v = (fin_pd[0] & fin_pd[1]) | (fin_pd[0] & fin_pd[2]) | (fin_pd[1] & fin_pd[2]);
  assign eff   = (settle < S_MIN) ? S_MIN : settle;
  assign evalv = (st != S_HOLD) && (wcnt >= eff - S_ONE);

  always_comb begin
    case (st)
      S_CRS:   begin up = crs_v;    top = &crs_code;  bot = ~|crs_code;  end
      S_FIN:   begin up = fin_v;    top = &fin_code;  bot = ~|fin_code;  end
      default: begin up = ~duty_hi; top = &duty_code; bot = ~|duty_code; end
    endcase
  end

  assign flip    = have_prev && (up != prev_up);
  assign blocked = up ? top : bot;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_CRS;
      wcnt      <= '0;
      have_prev <= 1'b0;
      prev_up   <= 1'b0;
      crs_code  <= C_MID;
      fin_code  <= F_MID;
      duty_code <= D_MID;
      locked    <= 1'b0;
      duty_ok   <= 1'b0;
      err       <= 1'b0;
    end else if (evalv) begin
      wcnt <= '0;
      if (flip) begin
        have_prev <= 1'b0;
        case (st)
          S_CRS:   st <= S_FIN;
          S_FIN:   begin st <= S_DUTY; locked <= 1'b1; end
          default: begin st <= S_HOLD; duty_ok <= 1'b1; end
        endcase
      end else if (blocked) begin
        err <= 1'b1;
        st  <= S_HOLD;
      end else begin
        have_prev <= 1'b1;
        prev_up   <= up;
        case (st)
          S_CRS:   crs_code  <= up ? crs_code + C_ONE  : crs_code - C_ONE;
          S_FIN:   fin_code  <= up ? fin_code + F_ONE  : fin_code - F_ONE;
          default: duty_code <= up ? duty_code + D_ONE : duty_code - D_ONE;
        endcase
      end
    end else if (st != S_HOLD) begin
      wcnt <= wcnt + S_ONE;
    end
  end

endmodule

// File: rtl/dll_lock_seq_chk.sv
module dll_lock_seq_chk #(
  parameter int CW = 3,
  parameter int FW = 6,
  parameter int DW = 5,
  parameter int MIN_SETTLE = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] crs_code,
  input logic [FW-1:0] fin_code,
  input logic [DW-1:0] duty_code,
  input logic          locked,
  input logic          duty_ok,
  input logic          err,
  input logic [1:0]    st
);

  logic [CW-1:0] pc;
  logic [FW-1:0] pf;
  logic [DW-1:0] pd;
  logic [7:0]    gap;
  logic          cc, fc, dc, chg;
  logic [CW-1:0] cdel;
  logic [FW-1:0] fdel;
  logic [DW-1:0] ddel;

  assign cc   = crs_code != pc;
  assign fc   = fin_code != pf;
  assign dc   = duty_code != pd;
  assign chg  = cc | fc | dc;
  assign cdel = crs_code - pc;
  assign fdel = fin_code - pf;
  assign ddel = duty_code - pd;

  always_ff @(posedge clk) begin
    pc <= crs_code;
    pf <= fin_code;
    pd <= duty_code;
    if (rst)              gap <= '0;
    else if (chg)         gap <= '0;
    else if (gap != 8'hff) gap <= gap + 8'd1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (crs_code == (CW'(1) << (CW-1))) && (fin_code == (FW'(1) << (FW-1)))
                   && (duty_code == (DW'(1) << (DW-1))) && !locked && !duty_ok && !err);

  // R3
  one_code_chk: assert property (@(posedge clk) disable iff (rst) $countones({cc, fc, dc}) <= 1);

  // R3
  unit_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cdel == '0 || cdel == CW'(1) || cdel == '1) && (fdel == '0 || fdel == FW'(1) || fdel == '1)
    && (ddel == '0 || ddel == DW'(1) || ddel == '1));

  // R3
  settle_gap_chk: assert property (@(posedge clk) disable iff (rst) chg |-> gap >= 8'(MIN_SETTLE - 1));

  // R4 (state 0 is the coarse phase)
  fine_idle_chk: assert property (@(posedge clk) disable iff (rst) (st == 2'd0) |=> $stable(fin_code));

  // R6
  duty_wait_chk: assert property (@(posedge clk) disable iff (rst) !locked |=> $stable(duty_code));

  // R6
  ok_after_lock_chk: assert property (@(posedge clk) disable iff (rst) duty_ok |-> locked);

  // R7
  err_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> err && $stable(crs_code) && $stable(fin_code) && $stable(duty_code)
            && $stable(locked) && $stable(duty_ok));

  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst) locked |=> locked);

endmodule

bind dll_lock_seq dll_lock_seq_chk #(.CW(CW), .FW(FW), .DW(DW), .MIN_SETTLE(MIN_SETTLE)) u_chk (
  .clk(clk), .rst(rst), .crs_code(crs_code), .fin_code(fin_code), .duty_code(duty_code),
  .locked(locked), .duty_ok(duty_ok), .err(err), .st(st)
);

// File: tb/tb_dll_lock_seq.sv
`timescale 1ns/1ps
module tb_dll_lock_seq;
  localparam int CW = 3, FW = 6, DW = 5, SW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [SW-1:0] settle = '0;
  logic [2:0] crs_pd, fin_pd;
  logic [2:0] cm = '0, fm = '0;
  logic duty_hi, force_hi = 1'b0;
  int tc = 4, tf = 32, td = 16;
  logic [CW-1:0] crs_code;
  logic [FW-1:0] fin_code;
  logic [DW-1:0] duty_code;
  logic locked, duty_ok, err;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    crs_pd  = {3{int'(crs_code) < tc}} ^ cm;
    fin_pd  = {3{int'(fin_code) < tf}} ^ fm;
    duty_hi = force_hi | (int'(duty_code) > td);
  end

  dll_lock_seq #(.CW(CW), .FW(FW), .DW(DW), .SW(SW)) dut (
    .clk(clk), .rst(rst), .settle(settle), .crs_pd(crs_pd), .fin_pd(fin_pd), .duty_hi(duty_hi),
    .crs_code(crs_code), .fin_code(fin_code), .duty_code(duty_code),
    .locked(locked), .duty_ok(duty_ok), .err(err)
  );

  task automatic chk(bit ok, string rq, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
    end
  endtask

  function automatic int m_code(int t, int w);
    int mx = (1 << w) - 1;
    int md = 1 << (w - 1);
    if (t > mx) return mx;
    if (t <= 0) return 0;
    if (t > md) return t;
    return t - 1;
  endfunction

  function automatic bit m_err(int t, int w);
    return (t > (1 << w) - 1) || (t <= 0);
  endfunction

  function automatic logic [2:0] one_flip();
    int r = $urandom_range(0, 3);
    return (r == 3) ? 3'b000 : (3'b001 << r);
  endfunction

  task automatic run(int a, int b, int c, int s, bit noisy, bit two, bit fhi);
    int eff = (s < 4) ? 4 : s;
    int cyc = 0, lc = 0, lf = -1, ld = -1;
    int sp_bad = 0, sp_act = 0, ord_bad = 0, lk_bad = 0, hold = 0;
    bit seen_lock = 0, ce, fe, de;
    int ec, ef, ed, el, eo;
    logic [CW-1:0] oc;
    logic [FW-1:0] of_;
    logic [DW-1:0] od;
    tc = a; tf = b; td = c; settle = SW'(s); force_hi = fhi;
    cm = two ? 3'b011 : 3'b000; fm = 3'b000;
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    // R1: reset state, also after a previous locked or failed run
    chk(crs_code == 3'd4 && fin_code == 6'd32 && duty_code == 5'd16 && !locked && !duty_ok && !err,
        "R1 reset", {locked, duty_ok, err}, 0);
    rst = 1'b0;
    oc = crs_code; of_ = fin_code; od = duty_code;
    while (hold < 2 * eff + 2 && cyc < 6000) begin
      @(negedge clk);
      cyc++;
      if (crs_code != oc) begin
        if (cyc - lc != eff) begin sp_bad++; sp_act = cyc - lc; end
        lc = cyc;
        if (fin_code != 6'd32 || duty_code != 5'd16) ord_bad++;
      end
      if (fin_code != of_) begin
        if (lf >= 0 && cyc - lf != eff) begin sp_bad++; sp_act = cyc - lf; end
        lf = cyc;
        if (duty_code != 5'd16) ord_bad++;
      end
      if (duty_code != od) begin
        if (ld >= 0 && cyc - ld != eff) begin sp_bad++; sp_act = cyc - ld; end
        ld = cyc;
        if (!locked) ord_bad++;
      end
      if (locked) seen_lock = 1;
      else if (seen_lock) lk_bad++;
      if (duty_ok || err) hold++;
      oc = crs_code; of_ = fin_code; od = duty_code;
      if (noisy) begin cm = one_flip(); fm = one_flip(); end
    end
    ce = two ? 1'b1 : m_err(a, CW);
    ec = two ? ((4 >= a) ? 7 : 0) : m_code(a, CW);
    fe = 0; de = 0; ef = 32; ed = 16; el = 0; eo = 0;
    if (!ce) begin
      fe = m_err(b, FW); ef = m_code(b, FW);
      if (!fe) begin
        el = 1;
        de = fhi ? 1'b1 : m_err(c + 1, DW);
        ed = fhi ? 0 : m_code(c + 1, DW);
        eo = de ? 0 : 1;
      end
    end
    chk(int'(crs_code) == ec, noisy ? "R2 R4 coarse code" : (two ? "R2 two copies" : "R4 coarse code"),
        int'(crs_code), ec);
    chk(int'(fin_code) == ef, noisy ? "R2 R5 fine code" : "R5 fine code", int'(fin_code), ef);
    chk(int'(duty_code) == ed, "R6 duty code", int'(duty_code), ed);
    chk(locked == el[0], "R5 locked", locked, el);
    chk(duty_ok == eo[0], "R6 duty_ok", duty_ok, eo);
    chk(err == (ce | fe | de), "R7 err", err, ce | fe | de);
    chk(sp_bad == 0, "R3 settle spacing", sp_act, eff);
    chk(ord_bad == 0, "R4 R6 phase order", ord_bad, 0);
    chk(lk_bad == 0, "R8 lock sticky", lk_bad, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_d11));
    // directed corners
    run(6, 40, 10, 0, 0, 0, 0);   // settle below floor -> 4
    run(4, 32, 16, 4, 0, 0, 0);   // targets at mid-scale
    run(7, 63, 30, 3, 0, 0, 0);   // upper reachable targets
    run(1, 1, 0, 6, 0, 0, 0);     // lower reachable targets
    run(8, 32, 16, 5, 0, 0, 0);   // coarse upper end stop
    run(0, 32, 16, 5, 0, 0, 0);   // coarse lower end stop
    run(5, 64, 16, 4, 0, 0, 0);   // fine upper end stop
    run(5, 20, 31, 4, 0, 0, 0);   // duty upper end stop
    run(5, 20, 12, 4, 0, 0, 1);   // duty lower end stop
    run(6, 40, 10, 4, 0, 1, 0);   // two copies flipped invert coarse
    // random runs with single-copy upsets
    for (int i = 0; i < 24; i++)
      run($urandom_range(0, 8), $urandom_range(0, 64), $urandom_range(0, 31),
          $urandom_range(0, 12), 1, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(150000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule